// File: doc/BRIEF.md
# General Register File with Narrow Register Views

The block holds sixty-four 64-bit general registers. Two read ports return data combinationally from the current contents, and one write port updates one entry on the rising clock edge. A per-port narrow flag switches an access to 32 bits: narrow reads return the low word, and narrow writes sign-extend a 32-bit value into the whole entry. The highest entry is a hardwired zero source and a write sink.

Several older 32-bit registers and one flag bit have no storage of their own. Each is a view onto part of a fixed entry of the file and has dedicated read and write pins. Every view uses the same flops as the main ports, so a value written through a view shows up at the main read ports one cycle later, and the reverse also holds. Each view has its own merge rule:

- the base and return views sign-extend their value into the full entry;
- the two accumulator halves each replace one half and keep the other;
- the flag replaces bit 0 only.

Top module: `gpr_alias_file`

## Requirements
- R1: Reading entry 63 on either port always returns zero, and a write of any width addressed to entry 63 changes nothing.
- R2: A full-width write stores all 64 bits at the rising edge. Both read ports are combinational. A read of the entry being written in the same cycle returns the previous contents.
- R3: With the read narrow flag set, the read port returns bits 31:0 of the entry in its low 32 bits and zeros in bits 63:32.
- R4: With the write narrow flag set, the entry receives bits 31:0 of the write data sign-extended from bit 31 to 64 bits.
- R5: Three views map to the low 32 bits of fixed entries: the global base view to entry 16, the return address view to entry 18, and the vector base view to entry 20. A write through any of these views sign-extends its 32-bit value into the whole entry.
- R6: The accumulator high view is bits 63:32 of entry 17 and the low view is bits 31:0. Writing one half leaves the other half unchanged. Writing both halves in the same cycle updates both.
- R7: The flag view is bit 0 of entry 19. A flag write replaces only bit 0 and keeps bits 63:1.
- R8: When the main write port and a view write target the same entry in the same cycle, the entry takes the main port's value.
- R9: After reset every entry reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_addr | input | 6 | Read port A entry index |
| rd_a_narrow | input | 1 | Read port A 32-bit mode |
| rd_a_data | output | 64 | Read port A data |
| rd_b_addr | input | 6 | Read port B entry index |
| rd_b_narrow | input | 1 | Read port B 32-bit mode |
| rd_b_data | output | 64 | Read port B data |
| wr_en | input | 1 | Main write enable |
| wr_addr | input | 6 | Main write entry index |
| wr_narrow | input | 1 | Main write 32-bit mode |
| wr_data | input | 64 | Main write data |
| gbase_rd | output | 32 | Global base view (entry 16 low) |
| gbase_we | input | 1 | Global base view write enable |
| gbase_wd | input | 32 | Global base view write data |
| retad_rd | output | 32 | Return address view (entry 18 low) |
| retad_we | input | 1 | Return address view write enable |
| retad_wd | input | 32 | Return address view write data |
| vbase_rd | output | 32 | Vector base view (entry 20 low) |
| vbase_we | input | 1 | Vector base view write enable |
| vbase_wd | input | 32 | Vector base view write data |
| acc_hi_rd | output | 32 | Accumulator high view (entry 17 bits 63:32) |
| acc_hi_we | input | 1 | Accumulator high write enable |
| acc_hi_wd | input | 32 | Accumulator high write data |
| acc_lo_rd | output | 32 | Accumulator low view (entry 17 bits 31:0) |
| acc_lo_we | input | 1 | Accumulator low write enable |
| acc_lo_wd | input | 32 | Accumulator low write data |
| tflag_rd | output | 1 | Flag view (entry 19 bit 0) |
| tflag_we | input | 1 | Flag write enable |
| tflag_wd | input | 1 | Flag write value |

## Verification
Read results arrive in the same cycle, with no register in the path. The bench therefore checks each read one time unit after it changes the address, and it also checks in the cycle of a write to the same entry, before the edge, to see the old value. Every write, whether main or view, becomes visible at the next rising edge at all read ports and views together. The bench samples those one time unit after that edge and compares against a model array that it updates by the merge rules of each view.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    parameter int GPR_COUNT  = 64;
    parameter int GPR_WIDTH  = 64;
    parameter int GPR_NARROW = 32;

    // View slots; each slot maps to one fixed entry of the file
    typedef enum int {
        SLOT_GBASE = 0,
        SLOT_ACC   = 1,
        SLOT_RETAD = 2,
        SLOT_TFLAG = 3,
        SLOT_VBASE = 4
    } view_slot_e;

    localparam int VIEW_SLOTS = 5;

endpackage

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
    parameter int NUM_REGS = 64,
    parameter int XLEN     = 64,
    parameter int HALF     = 32,
    parameter int ZERO_IDX = 63,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][XLEN-1:0] regs,
    input  logic [AW-1:0]                 addr,
    input  logic                          narrow,
    output logic [XLEN-1:0]               data
);

    logic [XLEN-1:0] raw;

    always_comb begin
        if (addr == AW'(ZERO_IDX)) begin
            raw = '0;
        end else begin
            raw = regs[addr];
        end
        if (narrow) begin
            data = {{(XLEN-HALF){1'b0}}, raw[HALF-1:0]};
        end else begin
            data = raw;
        end
    end

endmodule

// File: rtl/gpr_view_merge.sv
module gpr_view_merge
    import gpr_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int HALF = 32
) (
    input  logic [XLEN-1:0]                  cur_acc,
    input  logic [XLEN-1:0]                  cur_tflag,
    input  logic                             gbase_we,
    input  logic [HALF-1:0]                  gbase_wd,
    input  logic                             retad_we,
    input  logic [HALF-1:0]                  retad_wd,
    input  logic                             vbase_we,
    input  logic [HALF-1:0]                  vbase_wd,
    input  logic                             acc_hi_we,
    input  logic [HALF-1:0]                  acc_hi_wd,
    input  logic                             acc_lo_we,
    input  logic [HALF-1:0]                  acc_lo_wd,
    input  logic                             tflag_we,
    input  logic                             tflag_wd,
    output logic [VIEW_SLOTS-1:0]            hit,
    output logic [VIEW_SLOTS-1:0][XLEN-1:0]  value
);

    function automatic logic [XLEN-1:0] widen(input logic [HALF-1:0] v);
        return {{(XLEN-HALF){v[HALF-1]}}, v};
    endfunction

    always_comb begin
        hit   = '0;
        value = '0;

        hit[SLOT_GBASE]   = gbase_we;
        value[SLOT_GBASE] = widen(gbase_wd);

        hit[SLOT_RETAD]   = retad_we;
        value[SLOT_RETAD] = widen(retad_wd);

        hit[SLOT_VBASE]   = vbase_we;
        value[SLOT_VBASE] = widen(vbase_wd);

        // accumulator: each half replaced independently
        hit[SLOT_ACC]   = acc_hi_we | acc_lo_we;
        value[SLOT_ACC] = cur_acc;
        if (acc_hi_we) value[SLOT_ACC][XLEN-1:XLEN-HALF] = acc_hi_wd;
        if (acc_lo_we) value[SLOT_ACC][HALF-1:0]         = acc_lo_wd;

        // flag: bit 0 only
        hit[SLOT_TFLAG]   = tflag_we;
        value[SLOT_TFLAG] = {cur_tflag[XLEN-1:1], tflag_wd};
    end

endmodule

// File: rtl/gpr_alias_file.sv
module gpr_alias_file
    import gpr_pkg::*;
#(
    parameter int NUM_REGS  = GPR_COUNT,
    parameter int XLEN      = GPR_WIDTH,
    parameter int HALF      = GPR_NARROW,
    parameter int ZERO_IDX  = NUM_REGS - 1,
    parameter int GBASE_IDX = 16,
    parameter int ACC_IDX   = 17,
    parameter int RETAD_IDX = 18,
    parameter int TFLAG_IDX = 19,
    parameter int VBASE_IDX = 20,
    localparam int AW       = $clog2(NUM_REGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   rd_a_addr,
    input  logic            rd_a_narrow,
    output logic [XLEN-1:0] rd_a_data,
    input  logic [AW-1:0]   rd_b_addr,
    input  logic            rd_b_narrow,
    output logic [XLEN-1:0] rd_b_data,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic            wr_narrow,
    input  logic [XLEN-1:0] wr_data,
    output logic [HALF-1:0] gbase_rd,
    input  logic            gbase_we,
    input  logic [HALF-1:0] gbase_wd,
    output logic [HALF-1:0] retad_rd,
    input  logic            retad_we,
    input  logic [HALF-1:0] retad_wd,
    output logic [HALF-1:0] vbase_rd,
    input  logic            vbase_we,
    input  logic [HALF-1:0] vbase_wd,
    output logic [HALF-1:0] acc_hi_rd,
    input  logic            acc_hi_we,
    input  logic [HALF-1:0] acc_hi_wd,
    output logic [HALF-1:0] acc_lo_rd,
    input  logic            acc_lo_we,
    input  logic [HALF-1:0] acc_lo_wd,
    output logic            tflag_rd,
    input  logic            tflag_we,
    input  logic            tflag_wd
);

    typedef struct packed {
        logic [NUM_REGS-1:0][XLEN-1:0] regs;
    } file_state_t;

    file_state_t st_d, st_q;

    logic [VIEW_SLOTS-1:0]           view_hit;
    logic [VIEW_SLOTS-1:0][XLEN-1:0] view_val;
    logic [XLEN-1:0]                 main_val;

    localparam int SLOT_ENTRY [VIEW_SLOTS] = '{GBASE_IDX, ACC_IDX, RETAD_IDX, TFLAG_IDX, VBASE_IDX};

    gpr_view_merge #(.XLEN(XLEN), .HALF(HALF)) u_merge (
        .cur_acc   (st_q.regs[ACC_IDX]),
        .cur_tflag (st_q.regs[TFLAG_IDX]),
        .gbase_we  (gbase_we),
        .gbase_wd  (gbase_wd),
        .retad_we  (retad_we),
        .retad_wd  (retad_wd),
        .vbase_we  (vbase_we),
        .vbase_wd  (vbase_wd),
        .acc_hi_we (acc_hi_we),
        .acc_hi_wd (acc_hi_wd),
        .acc_lo_we (acc_lo_we),
        .acc_lo_wd (acc_lo_wd),
        .tflag_we  (tflag_we),
        .tflag_wd  (tflag_wd),
        .hit       (view_hit),
        .value     (view_val)
    );

    gpr_read_port #(.NUM_REGS(NUM_REGS), .XLEN(XLEN), .HALF(HALF), .ZERO_IDX(ZERO_IDX)) u_rd_a (
        .regs   (st_q.regs),
        .addr   (rd_a_addr),
        .narrow (rd_a_narrow),
        .data   (rd_a_data)
    );

    gpr_read_port #(.NUM_REGS(NUM_REGS), .XLEN(XLEN), .HALF(HALF), .ZERO_IDX(ZERO_IDX)) u_rd_b (
        .regs   (st_q.regs),
        .addr   (rd_b_addr),
        .narrow (rd_b_narrow),
        .data   (rd_b_data)
    );

    always_comb begin
        main_val = wr_narrow ? {{(XLEN-HALF){wr_data[HALF-1]}}, wr_data[HALF-1:0]} : wr_data;
        st_d = st_q;
        for (int s = 0; s < VIEW_SLOTS; s++) begin
            if (view_hit[s]) st_d.regs[SLOT_ENTRY[s]] = view_val[s];
        end
        // main port applied last so it overrides a view on the same entry
        if (wr_en && (wr_addr != AW'(ZERO_IDX))) begin
            st_d.regs[wr_addr] = main_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gbase_rd  = st_q.regs[GBASE_IDX][HALF-1:0];
    assign retad_rd  = st_q.regs[RETAD_IDX][HALF-1:0];
    assign vbase_rd  = st_q.regs[VBASE_IDX][HALF-1:0];
    assign acc_hi_rd = st_q.regs[ACC_IDX][XLEN-1:XLEN-HALF];
    assign acc_lo_rd = st_q.regs[ACC_IDX][HALF-1:0];
    assign tflag_rd  = st_q.regs[TFLAG_IDX][0];

    AST_ZERO_ENTRY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr == AW'(ZERO_IDX)) |-> (rd_a_data == '0)); // R1

    AST_NARROW_WRITE_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_narrow && wr_addr != AW'(ZERO_IDX)) |=>
        (st_q.regs[$past(wr_addr)] == {{(XLEN-HALF){$past(wr_data[HALF-1])}}, $past(wr_data[HALF-1:0])})); // R4

    AST_ACC_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_hi_we && !acc_lo_we && !(wr_en && wr_addr == AW'(ACC_IDX))) |=> $stable(acc_lo_rd)); // R6

    AST_ACC_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_lo_we && !acc_hi_we && !(wr_en && wr_addr == AW'(ACC_IDX))) |=> $stable(acc_hi_rd)); // R6

    AST_TFLAG_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (tflag_we && !(wr_en && wr_addr == AW'(TFLAG_IDX))) |=>
        (st_q.regs[TFLAG_IDX][XLEN-1:1] == $past(st_q.regs[TFLAG_IDX][XLEN-1:1]))); // R7

    AST_MAIN_BEATS_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_narrow && wr_addr == AW'(GBASE_IDX) && gbase_we) |=>
        (gbase_rd == $past(wr_data[HALF-1:0]))); // R8

endmodule

// File: tb/gpr_alias_file_test.sv
module gpr_alias_file_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
    logic        rd_a_narrow = 1'b0, rd_b_narrow = 1'b0, wr_en = 1'b0, wr_narrow = 1'b0;
    logic [63:0] rd_a_data, rd_b_data, wr_data = '0;
    logic [31:0] gbase_rd, retad_rd, vbase_rd, acc_hi_rd, acc_lo_rd;
    logic        gbase_we = 0, retad_we = 0, vbase_we = 0, acc_hi_we = 0, acc_lo_we = 0, tflag_we = 0;
    logic [31:0] gbase_wd = '0, retad_wd = '0, vbase_wd = '0, acc_hi_wd = '0, acc_lo_wd = '0;
    logic        tflag_wd = 1'b0, tflag_rd;

    int total = 0;
    int bad   = 0;
    logic [63:0] model [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpr_alias_file uut (.*);

    function automatic logic [63:0] sx(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
        wr_en = 0; gbase_we = 0; retad_we = 0; vbase_we = 0;
        acc_hi_we = 0; acc_lo_we = 0; tflag_we = 0;
    endtask

    task automatic full_wr(input int a, input logic [63:0] d);
        wr_en = 1; wr_narrow = 0; wr_addr = 6'(a); wr_data = d;
        tick();
        if (a != 63) model[a] = d;
    endtask

    task automatic read_all(input string req);
        rd_a_narrow = 0; rd_b_narrow = 0;
        for (int i = 0; i < 64; i++) begin
            rd_a_addr = 6'(i); rd_b_addr = 6'(63 - i);
            #1;
            chk(req, rd_a_data, (i == 63) ? 64'h0 : model[i]);
            chk(req, rd_b_data, (i == 0) ? 64'h0 : model[63 - i]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = '0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        // R9: every entry zero after reset
        read_all("R9");

        // R2 / R1: full-width sweep, old value seen during the write cycle
        for (int i = 0; i < 64; i++) begin
            logic [63:0] pat;
            pat = {32'(i) * 32'h9E37_79B9 ^ 32'h8000_0001, ~32'(i) ^ 32'h5A5A_0000};
            wr_en = 1; wr_narrow = 0; wr_addr = 6'(i); wr_data = pat;
            rd_a_addr = 6'(i); rd_a_narrow = 0;
            #1 chk("R2", rd_a_data, (i == 63) ? 64'h0 : model[i]);
            tick();
            if (i != 63) model[i] = pat;
        end
        read_all("R2");
        rd_a_addr = 6'd63; #1 chk("R1", rd_a_data, 64'h0);

        // R4: narrow writes sign-extend, both polarities of bit 31
        for (int i = 0; i < 64; i++) begin
            logic [31:0] lo;
            lo = (i % 2 == 1) ? (32'hC000_0000 | 32'(i * 7)) : 32'(i * 13);
            wr_en = 1; wr_narrow = 1; wr_addr = 6'(i); wr_data = {32'hDEAD_BEEF, lo};
            tick();
            if (i != 63) model[i] = sx(lo);
        end
        wr_narrow = 0;
        read_all("R4");
        rd_a_addr = 6'd63; #1 chk("R1", rd_a_data, 64'h0);

        // R3: narrow reads zero the upper half
        full_wr(5, 64'hFEDC_BA98_8765_4321);
        rd_a_narrow = 1; rd_b_narrow = 1;
        for (int i = 0; i < 64; i++) begin
            rd_a_addr = 6'(i); rd_b_addr = 6'(63 - i);
            #1;
            chk("R3", rd_a_data, (i == 63) ? 64'h0 : {32'h0, model[i][31:0]});
            chk("R3", rd_b_data, (i == 0) ? 64'h0 : {32'h0, model[63 - i][31:0]});
        end
        rd_a_narrow = 0; rd_b_narrow = 0;

        // R5: base and return views
        gbase_we = 1; gbase_wd = 32'h8765_4321;
        retad_we = 1; retad_wd = 32'h1234_5678;
        vbase_we = 1; vbase_wd = 32'hFFFF_0000;
        tick();
        model[16] = sx(32'h8765_4321); model[18] = sx(32'h1234_5678); model[20] = sx(32'hFFFF_0000);
        chk("R5", {32'h0, gbase_rd}, 64'h8765_4321);
        chk("R5", {32'h0, retad_rd}, 64'h1234_5678);
        chk("R5", {32'h0, vbase_rd}, 64'hFFFF_0000);
        rd_a_addr = 16; rd_b_addr = 18; #1;
        chk("R5", rd_a_data, model[16]);
        chk("R5", rd_b_data, model[18]);
        rd_a_addr = 20; #1 chk("R5", rd_a_data, model[20]);
        full_wr(18, 64'h0123_4567_89AB_CDEF);
        chk("R5", {32'h0, retad_rd}, 64'h89AB_CDEF);

        // R6: accumulator halves
        full_wr(17, 64'h1111_2222_3333_4444);
        acc_hi_we = 1; acc_hi_wd = 32'hAAAA_BBBB; tick();
        rd_a_addr = 17; #1 chk("R6", rd_a_data, 64'hAAAA_BBBB_3333_4444);
        acc_lo_we = 1; acc_lo_wd = 32'hCCCC_DDDD; tick();
        #1 chk("R6", rd_a_data, 64'hAAAA_BBBB_CCCC_DDDD);
        acc_hi_we = 1; acc_hi_wd = 32'h0000_0001; acc_lo_we = 1; acc_lo_wd = 32'h8000_0000; tick();
        chk("R6", {acc_hi_rd, acc_lo_rd}, 64'h0000_0001_8000_0000);
        model[17] = 64'h0000_0001_8000_0000;

        // R7: flag bit only
        full_wr(19, 64'hFFFF_FFFF_FFFF_FFFE);
        tflag_we = 1; tflag_wd = 1; tick();
        rd_a_addr = 19; #1 chk("R7", rd_a_data, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R7", {63'h0, tflag_rd}, 64'h1);
        full_wr(19, 64'h0000_0000_0000_0001);
        tflag_we = 1; tflag_wd = 0; tick();
        #1 chk("R7", rd_a_data, 64'h0);
        model[19] = 64'h0;

        // R8: main port beats a view on the same entry
        wr_en = 1; wr_narrow = 0; wr_addr = 16; wr_data = 64'h5555_6666_7777_8888;
        gbase_we = 1; gbase_wd = 32'h0BAD_0BAD; tick();
        rd_a_addr = 16; #1 chk("R8", rd_a_data, 64'h5555_6666_7777_8888);
        wr_en = 1; wr_addr = 17; wr_data = 64'h0101_0202_0303_0404;
        acc_hi_we = 1; acc_hi_wd = 32'hFFFF_FFFF; tick();
        rd_a_addr = 17; #1 chk("R8", rd_a_data, 64'h0101_0202_0303_0404);
        wr_en = 1; wr_addr = 19; wr_data = 64'h10; tflag_we = 1; tflag_wd = 1; tick();
        rd_a_addr = 19; #1 chk("R8", rd_a_data, 64'h10);

        // R1: writes of both widths to entry 63 vanish
        wr_en = 1; wr_narrow = 1; wr_addr = 63; wr_data = 64'hFFFF_FFFF_FFFF_FFFF; tick();
        wr_narrow = 0;
        rd_a_addr = 63; rd_b_addr = 63; #1;
        chk("R1", rd_a_data, 64'h0);
        chk("R1", rd_b_data, 64'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule